// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block gathers the interrupt events of a USB controller core and presents them to a host CPU as one level-sensitive interrupt line. Per-endpoint transmit and receive events and the core's bus events arrive as single-cycle pulses. They latch into two pending words: one endpoint word and one core word. Each word has its own enable mask. Software changes a mask only through a set register and a clear register, so no read-modify-write is needed. Software clears a pending bit by writing it back as a 1.

The interrupt line is held off after each assertion. It can rise again only after software writes an end-of-interrupt with bit 0 set. If enabled events are still pending at that point, the line drops for one cycle and then rises again, so an edge-sensitive interrupt controller also sees a fresh event.

The same register port also holds a fixed revision word, a control register whose bit 0 gives a one-cycle reset request to the core, a PHY control word, and a status word that reports the VBUS-drive state. The register port is a single-cycle read/write port. Read data is registered and is valid in the cycle after the read strobe.

Top module: `usbirq_wrap`

## Requirements
- R1: A read of byte offset 0x00 returns the parameter REV_ID, which is nonzero. A read of an unmapped offset, such as 0x10, returns 0.
- R2: Enable masks change only through their set and clear registers. Endpoint set is at 0x38 and endpoint clear is at 0x40. Core set is at 0x3C and core clear is at 0x44. A 1 in a set write turns that enable bit on. A 1 in a clear write turns it off. 0 bits leave the mask alone. A read of either the set or the clear offset returns the current mask.
- R3: Event pulses latch into pending status whether or not the bit is enabled. The endpoint word at 0x30 carries TX endpoint n at bit n (bits 15:0) and RX endpoint n at bit 16+n. Bit 16 (RX endpoint 0) never latches and never enables. The core word at 0x34 uses bits 8:0, and bit 8 is the VBUS-drive-change event.
- R4: Writing to a status offset clears exactly the bits written as 1. If an event pulse arrives in the same cycle as a clear of the same bit, the bit stays set.
- R5: When the line is armed and a pending bit is enabled, `irq` goes high one clock after the status or enable register that made the match is updated.
- R6: Once `irq` has risen, the line is disarmed. A write to offset 0x24 with bit 0 = 0 drops `irq` in the next cycle. The line does not rise again while it is disarmed, even if enabled bits are still pending.
- R7: A write to 0x24 with bit 0 = 1 drops `irq` and re-arms the line. If enabled status is still pending, `irq` rises again one cycle later. If nothing is pending, `irq` stays low.
- R8: Writing 1 to bit 0 of the control register at 0x14 gives a `core_rst` pulse exactly one cycle wide. The bit then reads back as 0.
- R9: The PHY control word at 0xE0 is read/write. It resets to PHY_RST, in which bit 21 is 1. `phy_otg_dis` follows bit 21 of this word.
- R10: Bit 0 of the status word at 0x18 reads the `vbus_drv` input.
- R11: A pending bit that is not enabled never raises `irq`. Enabling a bit that is already pending raises `irq` while the line is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| tx_evt | input | TX_N | Transmit endpoint event pulses |
| rx_evt | input | RX_N | Receive endpoint event pulses |
| core_evt | input | CORE_W | Core bus event pulses |
| vbus_drv | input | 1 | Current VBUS-drive state from the core |
| irq | output | 1 | Level interrupt to the CPU |
| core_rst | output | 1 | One-cycle reset request to the core |
| phy_ctl | output | 32 | PHY control word |
| phy_otg_dis | output | 1 | OTG-disable control to the PHY |

## Verification
The bench drives an event and a status clear in the same cycle. A design that lets the clear win would lose that event, and the status read-back would show the bit as 0.

The end-of-interrupt tests have three parts:
- A write of 0 must drop the line and keep it low while the event is still pending. A design that re-arms on every end-of-interrupt write would make the line rise again.
- A write of 1 must give a one-cycle gap and then a new rise.
- A write of 1 with nothing pending must leave the line low.

RX endpoint 0 is pulsed and set-enabled. A design that does not mask it would show bit 16 on read-back. Zero-bit enable writes and pending bits that are not enabled check that nothing reaches `irq` without an enable.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // byte offsets decoded by software drivers
  localparam logic [ADDR_W-1:0] A_REV       = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL      = 8'h14;
  localparam logic [ADDR_W-1:0] A_STAT      = 8'h18;
  localparam logic [ADDR_W-1:0] A_EOI       = 8'h24;
  localparam logic [ADDR_W-1:0] A_EP_PEND   = 8'h30;
  localparam logic [ADDR_W-1:0] A_CORE_PEND = 8'h34;
  localparam logic [ADDR_W-1:0] A_EP_SET    = 8'h38;
  localparam logic [ADDR_W-1:0] A_CORE_SET  = 8'h3C;
  localparam logic [ADDR_W-1:0] A_EP_CLR    = 8'h40;
  localparam logic [ADDR_W-1:0] A_CORE_CLR  = 8'h44;
  localparam logic [ADDR_W-1:0] A_PHY       = 8'hE0;

  localparam int OTG_DIS_BIT = 21;
endpackage

// File: rtl/usbirq_bank.sv
module usbirq_bank #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         w1c_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] pend_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= ((w1c_en ? (pend_q & ~wdata) : pend_q) | evt) & VALID;
      if (set_en)      en_q <= en_q | (wdata & VALID);
      else if (clr_en) en_q <= en_q & ~wdata;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign hit  = |(pend_q & en_q);

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((en & $past(wdata & VALID)) == $past(wdata & VALID)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((en & $past(wdata)) == '0));
  // R3
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((pend & $past(evt & VALID)) == $past(evt & VALID)));
  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    w1c_en |=> ((pend & $past(wdata & ~evt)) == '0));
endmodule

// File: rtl/usbirq_line.sv
module usbirq_line (
  input  logic clk,
  input  logic rst,
  input  logic any_hit,
  input  logic eoi_wr,
  input  logic eoi_arm,
  output logic irq
);
  logic arm_q, lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b1;
      lvl_q <= 1'b0;
    end else if (eoi_wr) begin
      lvl_q <= 1'b0;
      if (eoi_arm) arm_q <= 1'b1;
    end else if (arm_q && any_hit) begin
      lvl_q <= 1'b1;
      arm_q <= 1'b0;
    end
  end

  assign irq = lvl_q;

  // R5
  raise_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_q && any_hit && !eoi_wr) |=> irq);
  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !(eoi_wr && eoi_arm)) |=> !$rose(irq));
  // R6
  eoi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> !irq);
endmodule

// File: rtl/usbirq_wrap.sv
module usbirq_wrap
  import usbirq_pkg::*;
#(
  parameter int                TX_N    = 16,
  parameter int                RX_N    = 16,
  parameter int                CORE_W  = 9,
  parameter logic [DATA_W-1:0] REV_ID  = 32'h4E0A_0801,
  parameter logic [DATA_W-1:0] PHY_RST = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [CORE_W-1:0] core_evt,
  input  logic              vbus_drv,
  output logic              irq,
  output logic              core_rst,
  output logic [DATA_W-1:0] phy_ctl,
  output logic              phy_otg_dis
);
  localparam int EP_W = TX_N + RX_N;
  localparam logic [EP_W-1:0] EP_VALID =
    {{(RX_N-1){1'b1}}, 1'b0, {TX_N{1'b1}}};
  localparam logic [CORE_W-1:0] CORE_VALID = '1;

  logic wr, rd;
  assign wr = bus_en &  bus_we;
  assign rd = bus_en & ~bus_we;

  logic [EP_W-1:0]   ep_pend, ep_en;
  logic [CORE_W-1:0] core_pend, core_en;
  logic              ep_hit, core_hit;

  usbirq_bank #(.W(EP_W), .VALID(EP_VALID)) u_ep (
    .clk(clk), .rst(rst),
    .evt({rx_evt, tx_evt}),
    .w1c_en(wr && bus_addr == A_EP_PEND),
    .set_en(wr && bus_addr == A_EP_SET),
    .clr_en(wr && bus_addr == A_EP_CLR),
    .wdata(bus_wdata[EP_W-1:0]),
    .pend(ep_pend), .en(ep_en), .hit(ep_hit)
  );

  usbirq_bank #(.W(CORE_W), .VALID(CORE_VALID)) u_core (
    .clk(clk), .rst(rst),
    .evt(core_evt),
    .w1c_en(wr && bus_addr == A_CORE_PEND),
    .set_en(wr && bus_addr == A_CORE_SET),
    .clr_en(wr && bus_addr == A_CORE_CLR),
    .wdata(bus_wdata[CORE_W-1:0]),
    .pend(core_pend), .en(core_en), .hit(core_hit)
  );

  usbirq_line u_line (
    .clk(clk), .rst(rst),
    .any_hit(ep_hit | core_hit),
    .eoi_wr(wr && bus_addr == A_EOI),
    .eoi_arm(bus_wdata[0]),
    .irq(irq)
  );

  logic              rst_req_q;
  logic [DATA_W-1:0] phy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_q <= 1'b0;
      phy_q     <= PHY_RST;
    end else begin
      rst_req_q <= wr && bus_addr == A_CTRL && bus_wdata[0];
      if (wr && bus_addr == A_PHY) phy_q <= bus_wdata;
    end
  end

  assign core_rst    = rst_req_q;
  assign phy_ctl     = phy_q;
  assign phy_otg_dis = phy_q[OTG_DIS_BIT];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (bus_addr)
      A_REV:                  rd_mux = REV_ID;
      A_CTRL:                 rd_mux = DATA_W'(rst_req_q);
      A_STAT:                 rd_mux = DATA_W'(vbus_drv);
      A_EP_PEND:              rd_mux = DATA_W'(ep_pend);
      A_CORE_PEND:            rd_mux = DATA_W'(core_pend);
      A_EP_SET, A_EP_CLR:     rd_mux = DATA_W'(ep_en);
      A_CORE_SET, A_CORE_CLR: rd_mux = DATA_W'(core_en);
      A_PHY:                  rd_mux = phy_q;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> !core_rst);
  // R9
  phy_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_PHY) |=> (phy_ctl == $past(bus_wdata)));
endmodule

// File: tb/usbirq_wrap_test.sv
module usbirq_wrap_test;
  import usbirq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV = 32'h4E0A_0801;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] tx_evt = 0, rx_evt = 0;
  logic [8:0] core_evt = 0;
  logic vbus_drv = 0;
  logic irq, core_rst, phy_otg_dis;
  logic [31:0] phy_ctl;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbirq_wrap uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
    .vbus_drv(vbus_drv), .irq(irq), .core_rst(core_rst),
    .phy_ctl(phy_ctl), .phy_otg_dis(phy_otg_dis)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    tick();
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] t, input logic [15:0] r, input logic [8:0] c);
    tx_evt = t; rx_evt = r; core_evt = c;
    tick();
    tx_evt = 0; rx_evt = 0; core_evt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R5 irq after reset", {31'b0, irq}, 0);
    chk("R8 core_rst after reset", {31'b0, core_rst}, 0);
    chk("R9 otg_dis after reset", {31'b0, phy_otg_dis}, 1);
    rd(A_PHY, d);       chk("R9 phy reset value", d, 32'h0020_0000);
    rd(A_EP_PEND, d);   chk("R3 ep pend reset", d, 0);
    rd(A_CORE_SET, d);  chk("R2 core en reset", d, 0);
  endtask

  task automatic t_revision();
    logic [31:0] d;
    rd(A_REV, d); chk("R1 revision", d, REV);
    rd(8'h10, d); chk("R1 unmapped", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_EP_SET, 32'h0003_0005);
    rd(A_EP_SET, d);   chk("R2 ep set rx0 masked", d, 32'h0002_0005);
    wr(A_EP_SET, 32'h0);
    rd(A_EP_SET, d);   chk("R2 zero set no effect", d, 32'h0002_0005);
    wr(A_EP_CLR, 32'h0000_0004);
    rd(A_EP_CLR, d);   chk("R2 ep clear", d, 32'h0002_0001);
    wr(A_CORE_SET, 32'hFFFF_FFFF);
    rd(A_CORE_SET, d); chk("R2 core set width", d, 32'h0000_01FF);
    wr(A_CORE_CLR, 32'h0);
    rd(A_CORE_CLR, d); chk("R2 zero clear no effect", d, 32'h0000_01FF);
    wr(A_CORE_CLR, 32'h1FF);
    rd(A_CORE_CLR, d); chk("R2 core clear", d, 0);
    wr(A_EP_CLR, 32'hFFFF_FFFF);
    rd(A_EP_CLR, d);   chk("R2 ep clear all", d, 0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse(16'h8001, 16'h0003, 9'h100);
    rd(A_EP_PEND, d);   chk("R3 ep latch layout", d, 32'h0002_8001);
    rd(A_CORE_PEND, d); chk("R3 core latch", d, 32'h0000_0100);
    tick();
    chk("R11 disabled pending no irq", {31'b0, irq}, 0);
    wr(A_CORE_SET, 32'h100);
    tick();
    chk("R11 enable pending raises irq", {31'b0, irq}, 1);
    wr(A_CORE_PEND, 32'h100);
    wr(A_EOI, 32'h1);
    tick();
    chk("R7 eoi nothing pending", {31'b0, irq}, 0);
    wr(A_EP_PEND, 32'h0002_8001);
    rd(A_EP_PEND, d);   chk("R4 ep w1c all", d, 0);
    wr(A_CORE_CLR, 32'h1FF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(0, 0, 9'h00F);
    wr(A_CORE_PEND, 32'h5);
    rd(A_CORE_PEND, d); chk("R4 partial clear", d, 32'h0A);
    wr(A_CORE_PEND, 32'h0);
    rd(A_CORE_PEND, d); chk("R4 zero write keeps", d, 32'h0A);
    core_evt = 9'h002;
    wr(A_CORE_PEND, 32'h0A);
    core_evt = 0;
    rd(A_CORE_PEND, d); chk("R4 event beats clear", d, 32'h02);
    wr(A_CORE_PEND, 32'h1FF);
    rd(A_CORE_PEND, d); chk("R4 clear rest", d, 0);
  endtask

  task automatic t_eoi();
    wr(A_EP_SET, 32'h8);
    pulse(16'h0008, 0, 0);
    tick();
    chk("R5 irq rises", {31'b0, irq}, 1);
    wr(A_EOI, 32'h0);
    chk("R6 eoi0 drops", {31'b0, irq}, 0);
    tick(); tick();
    chk("R6 disarmed stays low", {31'b0, irq}, 0);
    wr(A_EOI, 32'h1);
    chk("R7 eoi1 gap", {31'b0, irq}, 0);
    tick();
    chk("R7 re-assert pending", {31'b0, irq}, 1);
    wr(A_EP_PEND, 32'h8);
    wr(A_EOI, 32'h1);
    tick();
    chk("R7 eoi1 clean stays low", {31'b0, irq}, 0);
    wr(A_EP_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    chk("R8 pulse high", {31'b0, core_rst}, 1);
    tick();
    chk("R8 pulse one cycle", {31'b0, core_rst}, 0);
    rd(A_CTRL, d); chk("R8 self clear readback", d, 0);
    wr(A_CTRL, 32'h0);
    chk("R8 zero write no pulse", {31'b0, core_rst}, 0);
  endtask

  task automatic t_phy();
    logic [31:0] d;
    wr(A_PHY, 32'h0);
    chk("R9 otg_dis cleared", {31'b0, phy_otg_dis}, 0);
    rd(A_PHY, d); chk("R9 phy readback", d, 0);
    wr(A_PHY, 32'h0020_0005);
    rd(A_PHY, d); chk("R9 phy readback2", d, 32'h0020_0005);
    chk("R9 otg_dis set", {31'b0, phy_otg_dis}, 1);
    chk("R9 phy_ctl port", phy_ctl, 32'h0020_0005);
  endtask

  task automatic t_vbus();
    logic [31:0] d;
    vbus_drv = 1;
    rd(A_STAT, d); chk("R10 vbus on", d, 1);
    vbus_drv = 0;
    rd(A_STAT, d); chk("R10 vbus off", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_revision();
    t_enable();
    t_latch();
    t_w1c();
    t_eoi();
    t_ctrl();
    t_phy();
    t_vbus();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule